// File: doc/BRIEF.md
# Phase-Shifted Resonant Balancer Gate Generator

This block drives the four switches of a capacitor-balancing stage made of two half-bridges joined through a series resonant tank. Each half-bridge runs at a fixed 50% duty. The second half-bridge is displaced in time from the first by a signed phase shift. That shift is the only control variable. Its sign sets which of the two stacked capacitors gives up charge, and its magnitude sets how much charge moves.

A single counter, clocked by the system clock, measures the switching period in clock cycles. The first leg is high for the first half of every period. The second leg is the same waveform, moved by the shift count and wrapped modulo the period. The shift command is clamped to plus or minus a quarter of the period, because transfer peaks at that limit. New period and shift settings take effect only at a period boundary, so no pulse is ever cut short. For a nominal 30 kHz switching rate the period setting is the clock frequency divided by 30 kHz. An outer balancing loop supplies the shift. Dead-time insertion follows this block.

Top module: `pbal_gate_gen`

## Requirements
- R1: While reset is asserted, and from the first clock edge at which `enable` is sampled low, all four gates are low.
- R2: When `enable` is sampled high while idle, the generator latches `period` and `shift`. It holds the gates low for that cycle, and the next cycle starts a period at count 0. Each gate value is registered, so it appears one clock after the count that produced it.
- R3: Within every period of P clock cycles (count c from 0 to P-1), `s1` is high for c < P/2 and low otherwise. `s2` is always the complement of `s1`, so both have exactly 50% duty.
- R4: `s3` is high when ((c - k) mod P) < P/2, where k is the effective shift. `s4` is always the complement of `s3`.
- R5: The shift is a two's-complement signed count. A positive value delays the `s3`/`s4` leg behind the `s1`/`s2` leg by k cycles. A negative value advances it by |k| cycles, which reverses the direction of charge transfer.
- R6: A shift command beyond the limit L = floor(P/4) saturates: commands above L become L, and commands below -L become -L.
- R7: A change of `shift` during a period has no effect until the next period. The value present at the last count of a period, at the clock edge where the count wraps, applies to the whole following period.
- R8: A change of `period` during a period takes effect at the same boundary as R7. The new saturation limit is derived from the new period. Legal periods are even and at least 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run request; low forces all gates off |
| period | input | CNT_W | Switching period in clock cycles (even, at least 4) |
| shift | input | CNT_W | Signed phase-shift command in clock cycles |
| s1 | output | 1 | First leg, upper switch |
| s2 | output | 1 | First leg, lower switch |
| s3 | output | 1 | Second leg, upper switch |
| s4 | output | 1 | Second leg, lower switch |

## Verification
The assertions assume that `period` is even and at least 4 whenever `enable` is high. Without that, the half-period compare cannot give an exact 50% duty and the count range check has no meaning. Every stimulus case in the bench keeps to this: it uses periods of 8, 10, 12, 16 and 20. It changes `period` only to another even value, and never while idle with an illegal value. Shift commands are deliberately allowed outside the quarter-period window, because saturation is part of the required behaviour.

// File: rtl/pbal_pkg.sv
package pbal_pkg;

    // Gate vector in switch order: first leg upper/lower, second leg upper/lower.
    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
        logic s4;
    } gates_t;

    localparam int unsigned NUM_LEGS = 2;

endpackage

// File: rtl/pbal_shift_clamp.sv
module pbal_shift_clamp #(
    parameter int CNT_W = 12
) (
    input  logic [CNT_W-1:0]        per,
    input  logic signed [CNT_W-1:0] cmd,
    output logic signed [CNT_W-1:0] sat
);

    logic signed [CNT_W-1:0] lim;
    logic signed [CNT_W-1:0] neg_lim;

    always_comb begin
        lim     = signed'({2'b00, per[CNT_W-1:2]});
        neg_lim = -lim;
        if (cmd > lim) begin
            sat = lim;
        end else if (cmd < neg_lim) begin
            sat = neg_lim;
        end else begin
            sat = cmd;
        end
    end

endmodule

// File: rtl/pbal_leg.sv
module pbal_leg #(
    parameter int CNT_W = 12
) (
    input  logic [CNT_W-1:0]        cnt,
    input  logic [CNT_W-1:0]        per,
    input  logic signed [CNT_W-1:0] ofs,
    output logic                    high
);

    localparam int EXT_W = CNT_W + 2;

    logic signed [EXT_W-1:0] per_s;
    logic signed [EXT_W-1:0] half_s;
    logic signed [EXT_W-1:0] pos_raw;
    logic signed [EXT_W-1:0] pos_wrap;

    always_comb begin
        per_s   = signed'({2'b00, per});
        half_s  = signed'({3'b000, per[CNT_W-1:1]});
        pos_raw = signed'({2'b00, cnt}) - signed'({ofs[CNT_W-1], ofs[CNT_W-1], ofs});
        if (pos_raw < 0) begin
            pos_wrap = pos_raw + per_s;
        end else if (pos_raw >= per_s) begin
            pos_wrap = pos_raw - per_s;
        end else begin
            pos_wrap = pos_raw;
        end
        high = (pos_wrap < half_s);
    end

endmodule

// File: rtl/pbal_gate_gen.sv
module pbal_gate_gen #(
    parameter int CNT_W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    enable,
    input  logic [CNT_W-1:0]        period,
    input  logic signed [CNT_W-1:0] shift,
    output logic                    s1,
    output logic                    s2,
    output logic                    s3,
    output logic                    s4
);

    import pbal_pkg::*;

    typedef struct packed {
        logic                    run;
        logic [CNT_W-1:0]        cnt;
        logic [CNT_W-1:0]        per;
        logic signed [CNT_W-1:0] sh;
        gates_t                  g;
    } state_t;

    state_t state_d, state_q;

    logic signed [CNT_W-1:0] sh_sat;
    logic signed [CNT_W-1:0] leg_ofs [NUM_LEGS];
    logic [NUM_LEGS-1:0]     leg_hi;
    logic                    last_cnt;

    pbal_shift_clamp #(.CNT_W(CNT_W)) u_clamp (
        .per (period),
        .cmd (shift),
        .sat (sh_sat)
    );

    assign leg_ofs[0] = '0;
    assign leg_ofs[1] = state_q.sh;

    for (genvar li = 0; li < NUM_LEGS; li++) begin : g_leg
        pbal_leg #(.CNT_W(CNT_W)) u_leg (
            .cnt  (state_q.cnt),
            .per  (state_q.per),
            .ofs  (leg_ofs[li]),
            .high (leg_hi[li])
        );
    end

    assign last_cnt = (state_q.cnt == state_q.per - 1'b1);

    always_comb begin
        state_d = state_q;
        if (!enable) begin
            state_d.run = 1'b0;
            state_d.cnt = '0;
            state_d.g   = '0;
        end else if (!state_q.run) begin
            state_d.run = 1'b1;
            state_d.cnt = '0;
            state_d.per = period;
            state_d.sh  = sh_sat;
            state_d.g   = '0;
        end else begin
            state_d.g.s1 = leg_hi[0];
            state_d.g.s2 = !leg_hi[0];
            state_d.g.s3 = leg_hi[1];
            state_d.g.s4 = !leg_hi[1];
            if (last_cnt) begin
                state_d.cnt = '0;
                state_d.per = period;
                state_d.sh  = sh_sat;
            end else begin
                state_d.cnt = state_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign s1 = state_q.g.s1;
    assign s2 = state_q.g.s2;
    assign s3 = state_q.g.s3;
    assign s4 = state_q.g.s4;

    // Checks kept beside the logic they guard.
    logic signed [CNT_W-1:0] lim_q;
    assign lim_q = signed'({2'b00, state_q.per[CNT_W-1:2]});

    assert_gates_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!s1 && !s2 && !s3 && !s4));

    assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !state_q.run) |=> (!s1 && !s2 && !s3 && !s4));

    assert_s1_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s1) |-> (state_q.cnt == 1));

    assert_cnt_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.run |-> (state_q.cnt < state_q.per));

    assert_shift_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.run |-> ((state_q.sh <= lim_q) && (state_q.sh >= -lim_q)));

    assert_hold_mid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.run && enable && !last_cnt) |=> ($stable(state_q.sh) && $stable(state_q.per)));

    assert_period_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        enable |-> ((period >= 4) && !period[0]));

endmodule

// File: tb/pbal_gate_gen_bench.sv
module pbal_gate_gen_bench;

    localparam int W = 12;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                enable = 1'b0;
    logic [W-1:0]        period = W'(8);
    logic signed [W-1:0] shift = '0;
    logic                s1, s2, s3, s4;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [3:0] v;
        string      tag;
    } exp_t;

    exp_t exp_q[$];

    always #10 clk = ~clk;

    pbal_gate_gen #(.CNT_W(W)) u_pbal_gate_gen (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (enable),
        .period (period),
        .shift  (shift),
        .s1     (s1),
        .s2     (s2),
        .s3     (s3),
        .s4     (s4)
    );

    function automatic logic [3:0] ref_gates(int c, int per, int sh);
        int lim  = per / 4;
        int k    = (sh > lim) ? lim : ((sh < -lim) ? -lim : sh);
        int half = per / 2;
        int pb   = (((c - k) % per) + per) % per;
        logic a  = (c < half);
        logic b  = (pb < half);
        return {a, !a, b, !b};
    endfunction

    task automatic direct_check(logic [3:0] exp, string tag);
        n_checks++;
        if ({s1, s2, s3, s4} !== exp) begin
            n_errors++;
            $display("FAIL %s: gates=%b expected=%b", tag, {s1, s2, s3, s4}, exp);
        end
    endtask

    // Monitor: one expected vector per falling edge while items are queued.
    always @(negedge clk) begin
        if (exp_q.size() != 0) begin
            exp_t it;
            it = exp_q.pop_front();
            direct_check(it.v, it.tag);
        end
    end

    task automatic push(logic [3:0] v, string tag);
        exp_t it;
        it.v   = v;
        it.tag = tag;
        exp_q.push_back(it);
    endtask

    // Ends every case: enable drops, gates must be off one clock later (R1).
    task automatic stop_run();
        push(4'b0000, "R1 disable");
        enable = 1'b0;
        repeat (3) @(negedge clk);
        #1;
    endtask

    task automatic run_case(int per, int sh, int nper, string tag);
        period = W'(per);
        shift  = W'(sh);
        enable = 1'b1;
        @(posedge clk);
        #1;
        push(4'b0000, "R2 start");
        for (int i = 0; i < nper * per; i++) push(ref_gates(i % per, per, sh), tag);
        repeat (1 + nper * per) @(negedge clk);
        #1;
        stop_run();
    endtask

    // Change settings mid-period; the first period keeps the old values.
    task automatic run_change(int per0, int sh0, int per1, int sh1, string tag);
        period = W'(per0);
        shift  = W'(sh0);
        enable = 1'b1;
        @(posedge clk);
        #1;
        push(4'b0000, "R2 start");
        for (int i = 0; i < per0; i++) push(ref_gates(i, per0, sh0), tag);
        for (int i = 0; i < 2 * per1; i++) push(ref_gates(i % per1, per1, sh1), tag);
        repeat (per0 / 2) @(negedge clk);
        #1;
        period = W'(per1);
        shift  = W'(sh1);
        repeat (1 + per0 + 2 * per1 - per0 / 2) @(negedge clk);
        #1;
        stop_run();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        direct_check(4'b0000, "R1 reset");
        #1;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        direct_check(4'b0000, "R1 idle");
        run_case(8, 0, 3, "R3 R4 zero shift");
        run_case(12, 2, 2, "R5 positive shift");
        run_case(12, -3, 2, "R5 negative shift");
        run_case(10, 1, 2, "R4 odd quarter");
        run_case(16, 9, 2, "R6 saturate high");
        run_case(16, -100, 2, "R6 saturate low");
        run_change(12, 1, 12, -3, "R7 shift update");
        run_change(8, 2, 20, 5, "R8 period update");
        run_change(20, -5, 8, 7, "R8 R6 shrink with clamp");
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule